// File: doc/BRIEF.md
# Port GPIO Interrupt Generator

This block turns the pins of one general-purpose I/O port into a single interrupt request. Each pin can be set to detect edges or levels. In edge mode it detects a rising edge, a falling edge or either edge; in level mode it detects a high or a low level. Each pin input passes through a two-flop synchronizer. An edge is detected by comparing the synchronized value with its value one clock earlier.

Edge events are held in a raw status register until software clears them by writing 1 to the clear register. Level events follow the pin. A per-pin enable gates raw status into a masked status register, and the OR of the masked bits drives the port interrupt. An interrupt handler reads the raw or masked status to find out which pins fired.

The register port is a simple synchronous interface. A write takes effect at the clock edge on which the write strobe is high. Read data is combinational from the address.

Top module: `gpio_irq_gen`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: Enable (address 0), sense (address 1, bit 1 = level mode), both-edges (address 2) and polarity (address 3) are read/write registers. A write to any of them reads back unchanged.
- R3: Address 4 reads raw status. Address 5 reads masked status, which equals raw AND enable. Address 6 is the write-one-to-clear register and reads 0. Writes to addresses 4 and 5 have no effect.
- R4: With sense=0, both=0 and polarity=1, a 0-to-1 change on a pin sets its raw bit. The bit becomes visible after the third rising clock edge following the change. A 1-to-0 change does not set the bit.
- R5: With sense=0, both=0 and polarity=0, only a 1-to-0 change sets the raw bit.
- R6: With sense=0 and both=1, any change on the pin sets the raw bit, whatever the polarity setting.
- R7: An edge event stays latched until a 1 is written to that bit at address 6. A 0 written to a bit leaves that bit unchanged.
- R8: With sense=1, the raw bit is 1 while the synchronized pin equals the polarity bit and 0 otherwise. A clear write has no effect while the level persists. The both-edges bit is ignored in this mode.
- R9: `irq_o` is high exactly when at least one pin has both its raw bit and its enable bit set.
- R10: The raw bit records events on pins that are not enabled. Enabling a pin whose raw bit is already set raises `irq_o` right after the enable write.
- R11: Events on several pins in the same cycle are all recorded in raw status.
- R12: When a new edge event arrives in the same cycle as a clear of that bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | N_PINS | Asynchronous pin inputs |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | N_PINS | Write data |
| rdata_o | output | N_PINS | Read data for `addr_i` |
| irq_o | output | 1 | Port interrupt request |

## Verification
The hardest case to reach is a clear write that falls in the same cycle as a new edge event on the same pin. The bench counts clock edges from the pin change through the synchronizer and drives the clear strobe so that it is sampled on exactly the edge at which the detector fires.

A second case is a latched event on a disabled pin. The bench raises the event while the enable is 0, confirms that `irq_o` stays low, and then writes the enable and checks `irq_o` one cycle later.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_EN    = 3'd0,
    A_SENSE = 3'd1,
    A_BOTH  = 3'd2,
    A_POL   = 3'd3,
    A_RAW   = 3'd4,
    A_MASK  = 3'd5,
    A_CLR   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] sync_o,
  output logic [N_PINS-1:0] prev_o
);
  logic [N_PINS-1:0] meta_q, sync_q, prev_q;
  logic [1:0] warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  // cycles since reset, saturating; only qualifies the assertion below
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;

  AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q[1] |-> (sync_o == $past(pin_i, 2))); // R4
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] sync_i,
  input  logic [N_PINS-1:0] prev_i,
  input  logic [N_PINS-1:0] sense_i,
  input  logic [N_PINS-1:0] both_i,
  input  logic [N_PINS-1:0] pol_i,
  input  logic [N_PINS-1:0] clr_i,
  output logic [N_PINS-1:0] raw_o
);
  logic [N_PINS-1:0] raw_q;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic rise, fall, edge_ev, lvl_ev;
    assign rise    = sync_i[i] & ~prev_i[i];
    assign fall    = ~sync_i[i] & prev_i[i];
    assign edge_ev = both_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall);
    assign lvl_ev  = ~(sync_i[i] ^ pol_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        raw_q[i] <= 1'b0;
      else if (sense_i[i]) raw_q[i] <= lvl_ev;
      else                raw_q[i] <= (raw_q[i] & ~clr_i[i]) | edge_ev;  // new event beats clear
    end

    AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raw_q[i] && !sense_i[i] && !clr_i[i]) |=> (raw_q[i] || sense_i[i])); // R7
    AST_LEVEL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_i[i] && (sync_i[i] == pol_i[i])) |=> raw_q[i]); // R8
    AST_LEVEL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_i[i] && (sync_i[i] != pol_i[i])) |=> !raw_q[i]); // R8
    AST_CLR_RACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sense_i[i] && !both_i[i] && pol_i[i] && sync_i[i] && !prev_i[i]) |=> raw_q[i]); // R12
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  input  logic [N_PINS-1:0] raw_i,
  output logic [N_PINS-1:0] rdata_o,
  output logic [N_PINS-1:0] en_o,
  output logic [N_PINS-1:0] sense_o,
  output logic [N_PINS-1:0] both_o,
  output logic [N_PINS-1:0] pol_o,
  output logic [N_PINS-1:0] clr_o
);
  logic [N_PINS-1:0] en_q, sense_q, both_q, pol_q;
  reg_addr_e addr;
  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
    end else if (we_i) begin
      case (addr)
        A_EN:    en_q    <= wdata_i;
        A_SENSE: sense_q <= wdata_i;
        A_BOTH:  both_q  <= wdata_i;
        A_POL:   pol_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_o = (we_i && addr == A_CLR) ? wdata_i : '0;

  always_comb begin
    case (addr)
      A_EN:    rdata_o = en_q;
      A_SENSE: rdata_o = sense_q;
      A_BOTH:  rdata_o = both_q;
      A_POL:   rdata_o = pol_q;
      A_RAW:   rdata_o = raw_i;
      A_MASK:  rdata_o = raw_i & en_q;
      default: rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign pol_o   = pol_q;

  AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr == A_EN) |=> (en_o == $past(wdata_i))); // R2
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(en_o) && $stable(sense_o) && $stable(both_o) && $stable(pol_o))); // R3
endmodule

// File: rtl/gpio_irq_gen.sv
module gpio_irq_gen
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] sync, prev, raw, en, sense, both, pol, clr;

  gpio_irq_sync #(.N_PINS(N_PINS)) u_sync (
    .clk_i, .rst_ni, .pin_i, .sync_o(sync), .prev_o(prev)
  );

  gpio_irq_detect #(.N_PINS(N_PINS)) u_detect (
    .clk_i, .rst_ni, .sync_i(sync), .prev_i(prev), .sense_i(sense),
    .both_i(both), .pol_i(pol), .clr_i(clr), .raw_o(raw)
  );

  gpio_irq_regs #(.N_PINS(N_PINS)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .raw_i(raw), .rdata_o,
    .en_o(en), .sense_o(sense), .both_o(both), .pol_o(pol), .clr_o(clr)
  );

  assign irq_o = |(raw & en);

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en != '0)); // R9
  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($countones(raw) != 0)); // R9
  AST_IRQ_ON_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_EN && ((raw & wdata_i) != '0) && (sense == '0) && (clr == '0)) |=> irq_o); // R10
endmodule

// File: tb/gpio_irq_gen_test.sv
module gpio_irq_gen_test;
  localparam int unsigned N = 8;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [N-1:0] pin = '0, wdata = '0, rdata;
  logic [2:0] addr = '0;
  logic irq;
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_irq_gen #(.N_PINS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // {sense, both, pol, start, end, expected raw bit}
  localparam logic [5:0] VEC [10] = '{
    6'b001_01_1, 6'b001_10_0, 6'b000_10_1, 6'b000_01_0, 6'b010_01_1,
    6'b011_10_1, 6'b101_01_1, 6'b100_01_0, 6'b100_10_1, 6'b111_00_0
  };

  function automatic string tag_of(input logic [5:0] v);
    if (v[5])      return "R8";
    else if (v[4]) return "R6";
    else if (v[3]) return "R4";
    else           return "R5";
  endfunction

  initial begin
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] d;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    for (int a = 0; a < 7; a++) begin rd(3'(a), d); check("R1", d, '0); end
    check("R1 irq", {7'b0, irq}, '0);

    // R2 read/write config
    wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'h0F); wr(3'd3, 8'hF0);
    rd(3'd0, d); check("R2 en", d, 8'hA5);
    rd(3'd1, d); check("R2 sense", d, 8'h3C);
    rd(3'd2, d); check("R2 both", d, 8'h0F);
    rd(3'd3, d); check("R2 pol", d, 8'hF0);
    wr(3'd0, '0); wr(3'd1, '0); wr(3'd2, '0); wr(3'd3, '0);

    // vector table on pin 0
    foreach (VEC[i]) begin
      wr(3'd1, {7'b0, VEC[i][5]});
      wr(3'd2, {7'b0, VEC[i][4]});
      wr(3'd3, {7'b0, VEC[i][3]});
      pin[0] = VEC[i][2];
      wait_n(4);
      wr(3'd6, 8'hFF);
      pin[0] = VEC[i][1];
      wait_n(4);
      rd(3'd4, d);
      check(tag_of(VEC[i]), {7'b0, d[0]}, {7'b0, VEC[i][0]});
    end
    pin = '0;
    wr(3'd1, '0); wr(3'd2, '0); wr(3'd3, 8'hFF);
    wait_n(4); wr(3'd6, 8'hFF);
    rd(3'd4, d); check("R7 cleared", d, '0);

    // R11 simultaneous rising on pins 1,2,5; R7 selective clear
    pin = 8'h26; wait_n(3);
    rd(3'd4, d); check("R11", d, 8'h26);
    wr(3'd6, 8'h02);
    rd(3'd4, d); check("R7 partial", d, 8'h24);
    wait_n(3);
    rd(3'd4, d); check("R7 hold", d, 8'h24);

    // R3 raw/mask writes ignored, clear reads 0, mask = raw & en
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    rd(3'd4, d); check("R3 raw ro", d, 8'h24);
    rd(3'd6, d); check("R3 clr read", d, '0);
    rd(3'd5, d); check("R3 mask", d, 8'h00);
    // R10 disabled pins recorded, irq low; enable raises irq
    check("R10 irq off", {7'b0, irq}, '0);
    wr(3'd0, 8'h04);
    check("R10 irq on", {7'b0, irq}, 8'h01);
    rd(3'd5, d); check("R3 mask", d, 8'h04);
    // R9 irq drops when masked bit cleared though another raw bit stays
    wr(3'd6, 8'h04);
    check("R9 irq low", {7'b0, irq}, '0);
    rd(3'd4, d); check("R9 raw", d, 8'h20);
    wr(3'd6, 8'hFF);
    pin = '0; wait_n(4);

    // R12 clear coinciding with new edge on pin 3
    @(negedge clk); pin[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    we = 1'b1; addr = 3'd6; wdata = 8'h08;
    @(negedge clk); we = 1'b0; wdata = '0;
    rd(3'd4, d); check("R12", d, 8'h08);
    wr(3'd6, 8'h08);
    rd(3'd4, d); check("R12 later clear", d, '0);

    // R8 level active: clear ignored, drops with level
    wr(3'd1, 8'h08); wait_n(1);
    wr(3'd6, 8'h08);
    rd(3'd4, d); check("R8 clr ignored", d, 8'h08);
    pin[3] = 1'b0; wait_n(3);
    rd(3'd4, d); check("R8 drop", d, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule